// File: doc/BRIEF.md
# Programmable Stochastic Gate Fabric

This block is a small netlist of bit-serial gates whose wiring is set at run time. Each of a fixed number of instruction slots holds an opcode, up to three source wire indices and one destination wire index. Once per clock the fabric takes the current bit of every input stream and evaluates all combinational slots on it. It then advances its one-bit state elements, which are delay and toggle cells. Any wire can be chosen as the output through a separate tap register.

The wire space has 16 entries. The lowest `NUM_INPUTS` wires carry the input stream bits. The other wires are driven by slots, or read as 0 when no slot drives them. The block checks every loaded program and raises a flag when that program is illegal. A program is illegal when a wire has more than one driver, or when the combinational slots form a feedback loop. Slots can be written in any order, and the result never depends on which slot holds which instruction.

Top module: `sgf_fabric`

## Requirements
- R1: After reset every slot is empty (valid bit 0), the tap selects wire 0, all state cells are 0, `prog_err` is 0 and `out_bit` equals `in_bits[0]`.
- R2: A write with `prog_we` high and `prog_addr` below `NUM_SLOTS` stores `prog_data` in that slot. The layout of `prog_data` is: bit 19 valid, bits 18:16 opcode, bits 15:12 source A, bits 11:8 source B, bits 7:4 select source, bits 3:0 destination. A write to address `NUM_SLOTS` stores `prog_data[3:0]` as the tap. Both take effect from the cycle after the write edge.
- R3: Wires 0 to `NUM_INPUTS-1` carry `in_bits`. The combinational opcodes act in the same cycle: 0 is A AND B, 1 is A OR B, 2 is A XOR B, 3 is NOT A, 4 copies A, and 7 selects A when the select wire is 1 and B otherwise.
- R4: Opcode 5 drives its destination with the value that source A had in the previous enabled cycle.
- R5: Opcode 6 drives its destination with a cell that inverts after every enabled cycle in which source A was 1.
- R6: Every write to a slot or to the tap clears all state cells to 0.
- R7: While `en` is 0 the state cells hold their value, and the combinational gates still follow the inputs.
- R8: `prog_err` is 1, and `out_bit` is forced to 0, when two valid slots share a destination or a valid slot targets an input wire.
- R9: `prog_err` is 1, and `out_bit` is 0, when valid combinational slots form a loop. A loop that passes through an opcode 5 or 6 cell is legal.
- R10: Placing the same instructions in different slots gives identical output streams.
- R11: A wire at or above `NUM_INPUTS` that no valid slot drives reads 0.
- R12: A chain of `NUM_SLOTS` combinational slots settles within the same cycle, whatever order the slots hold it in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_we | input | 1 | Load strobe for a slot or the tap |
| prog_addr | input | $clog2(NUM_SLOTS+1) | Slot index, or `NUM_SLOTS` for the tap |
| prog_data | input | 20 | Packed instruction, or tap index in bits 3:0 |
| en | input | 1 | Advance the state cells this cycle |
| in_bits | input | NUM_INPUTS | Current bit of each input stream |
| out_bit | output | 1 | Value of the tapped wire, 0 when the program is illegal |
| prog_err | output | 1 | Loaded program is illegal |

## Verification
The bench builds the block with its defaults: four input wires and eight slots over the 16-wire space. Eight slots are enough for a chain that is reversed across the whole slot range, which drives the settling logic to its full depth. Eight random destinations spread over twelve non-input wires make both legal and conflicting programs common. The random programs also form loops, with and without state cells in them. The tap address equals the slot count, so it sits right at the top of the decoded address range.

// File: rtl/sgf_pkg.sv
package sgf_pkg;

    localparam int SGF_WIRES = 16;
    localparam int WIRE_W    = $clog2(SGF_WIRES);

    typedef enum logic [2:0] {
        OP_AND  = 3'd0,
        OP_OR   = 3'd1,
        OP_XOR  = 3'd2,
        OP_NOT  = 3'd3,
        OP_PASS = 3'd4,
        OP_DFF  = 3'd5,
        OP_TFF  = 3'd6,
        OP_MUX  = 3'd7
    } op_e;

    typedef struct packed {
        logic              vld;
        op_e               op;
        logic [WIRE_W-1:0] a;
        logic [WIRE_W-1:0] b;
        logic [WIRE_W-1:0] s;
        logic [WIRE_W-1:0] d;
    } instr_t;

    localparam int INSTR_W = $bits(instr_t);

    // Opcodes that own a state cell.
    function automatic logic is_state(input op_e op);
        return (op == OP_DFF) || (op == OP_TFF);
    endfunction

    // Opcodes that read source B.
    function automatic logic uses_b(input op_e op);
        return (op == OP_AND) || (op == OP_OR) || (op == OP_XOR) || (op == OP_MUX);
    endfunction

    // Opcodes that read the select source.
    function automatic logic uses_s(input op_e op);
        return op == OP_MUX;
    endfunction

    // Same-cycle gate function.
    function automatic logic gate_fn(input op_e op, input logic va,
                                     input logic vb, input logic vs);
        logic r;
        case (op)
            OP_AND:  r = va & vb;
            OP_OR:   r = va | vb;
            OP_XOR:  r = va ^ vb;
            OP_NOT:  r = ~va;
            OP_PASS: r = va;
            OP_MUX:  r = vs ? va : vb;
            default: r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/sgf_cfg_store.sv
module sgf_cfg_store
    import sgf_pkg::*;
#(
    parameter int NUM_SLOTS = 8,
    parameter int ADDR_W    = $clog2(NUM_SLOTS + 1)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      we,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [INSTR_W-1:0]        data,
    output instr_t [NUM_SLOTS-1:0]    prog_q,
    output logic [WIRE_W-1:0]         tap_q,
    output logic                      clr
);

    localparam logic [ADDR_W-1:0] TAP_ADDR = ADDR_W'(NUM_SLOTS);

    // Any write that lands on a slot or the tap restarts the state cells.
    assign clr = we && (addr <= TAP_ADDR);

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(g);
        always_ff @(posedge clk) begin
            if (rst) begin
                prog_q[g] <= '0;
            end else if (we && addr == MY_ADDR) begin
                prog_q[g] <= instr_t'(data);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tap_q <= '0;
        end else if (we && addr == TAP_ADDR) begin
            tap_q <= data[WIRE_W-1:0];
        end
    end

endmodule

// File: rtl/sgf_legality.sv
module sgf_legality
    import sgf_pkg::*;
#(
    parameter int NUM_INPUTS = 4,
    parameter int NUM_SLOTS  = 8
) (
    input  instr_t [NUM_SLOTS-1:0] prog,
    output logic                   conflict,
    output logic                   loop
);

    logic [SGF_WIRES-1:0] driven;
    logic [SGF_WIRES-1:0] ready0;
    logic [SGF_WIRES-1:0] ready;
    logic [SGF_WIRES-1:0] ready_nxt;
    logic [NUM_SLOTS-1:0] comb_slot;

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_kind
        assign comb_slot[g] = prog[g].vld && !is_state(prog[g].op);
    end

    // Driver count: input wires start as driven by the port.
    always_comb begin
        driven   = '0;
        conflict = 1'b0;
        for (int i = 0; i < NUM_INPUTS; i++) begin
            driven[i] = 1'b1;
        end
        for (int s = 0; s < NUM_SLOTS; s++) begin
            if (prog[s].vld) begin
                if (driven[prog[s].d]) begin
                    conflict = 1'b1;
                end
                driven[prog[s].d] = 1'b1;
            end
        end
    end

    // Readiness propagation: a gate output becomes ready once all the
    // sources it reads are ready. Whatever stays unready sits on a loop.
    always_comb begin
        ready0 = '1;
        for (int s = 0; s < NUM_SLOTS; s++) begin
            if (comb_slot[s]) begin
                ready0[prog[s].d] = 1'b0;
            end
        end
        ready = ready0;
        for (int p = 0; p < NUM_SLOTS; p++) begin
            ready_nxt = ready0;
            for (int s = 0; s < NUM_SLOTS; s++) begin
                if (comb_slot[s] && ready[prog[s].a]
                    && (!uses_b(prog[s].op) || ready[prog[s].b])
                    && (!uses_s(prog[s].op) || ready[prog[s].s])) begin
                    ready_nxt[prog[s].d] = 1'b1;
                end
            end
            ready = ready_nxt;
        end
        loop = 1'b0;
        for (int s = 0; s < NUM_SLOTS; s++) begin
            if (comb_slot[s] && !ready[prog[s].d]) begin
                loop = 1'b1;
            end
        end
    end

endmodule

// File: rtl/sgf_eval.sv
module sgf_eval
    import sgf_pkg::*;
#(
    parameter int NUM_INPUTS = 4,
    parameter int NUM_SLOTS  = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   clr,
    input  logic                   en,
    input  logic [NUM_INPUTS-1:0]  in_bits,
    input  instr_t [NUM_SLOTS-1:0] prog,
    output logic [SGF_WIRES-1:0]   wires,
    output logic [NUM_SLOTS-1:0]   state_q
);

    logic [SGF_WIRES-1:0] base;
    logic [SGF_WIRES-1:0] cur;
    logic [SGF_WIRES-1:0] nxt;

    // Wire values: inputs, state cell outputs, then NUM_SLOTS relaxation
    // passes over the gates. Each pass rebuilds from the base, so an
    // acyclic network of at most NUM_SLOTS gates settles independent of
    // the slot order.
    always_comb begin
        base = '0;
        for (int i = 0; i < NUM_INPUTS; i++) begin
            base[i] = in_bits[i];
        end
        for (int s = 0; s < NUM_SLOTS; s++) begin
            if (prog[s].vld && is_state(prog[s].op)) begin
                base[prog[s].d] = state_q[s];
            end
        end
        cur = base;
        for (int p = 0; p < NUM_SLOTS; p++) begin
            nxt = base;
            for (int s = 0; s < NUM_SLOTS; s++) begin
                if (prog[s].vld && !is_state(prog[s].op)) begin
                    nxt[prog[s].d] = gate_fn(prog[s].op, cur[prog[s].a],
                                             cur[prog[s].b], cur[prog[s].s]);
                end
            end
            cur = nxt;
        end
        wires = cur;
    end

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_cell
        always_ff @(posedge clk) begin
            if (rst || clr) begin
                state_q[g] <= 1'b0;
            end else if (en) begin
                if (prog[g].vld && prog[g].op == OP_DFF) begin
                    state_q[g] <= wires[prog[g].a];
                end else if (prog[g].vld && prog[g].op == OP_TFF) begin
                    state_q[g] <= state_q[g] ^ wires[prog[g].a];
                end else begin
                    state_q[g] <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/sgf_fabric.sv
module sgf_fabric
    import sgf_pkg::*;
#(
    parameter int NUM_INPUTS = 4,
    parameter int NUM_SLOTS  = 8,
    localparam int ADDR_W    = $clog2(NUM_SLOTS + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  prog_we,
    input  logic [ADDR_W-1:0]     prog_addr,
    input  logic [INSTR_W-1:0]    prog_data,
    input  logic                  en,
    input  logic [NUM_INPUTS-1:0] in_bits,
    output logic                  out_bit,
    output logic                  prog_err
);

    instr_t [NUM_SLOTS-1:0] prog_q;
    logic [WIRE_W-1:0]      tap_q;
    logic                   cfg_clr;
    logic                   conflict;
    logic                   loop;
    logic [SGF_WIRES-1:0]   wires;
    logic [NUM_SLOTS-1:0]   state_q;

    sgf_cfg_store #(.NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W)) u_cfg (
        .clk    (clk),
        .rst    (rst),
        .we     (prog_we),
        .addr   (prog_addr),
        .data   (prog_data),
        .prog_q (prog_q),
        .tap_q  (tap_q),
        .clr    (cfg_clr)
    );

    sgf_legality #(.NUM_INPUTS(NUM_INPUTS), .NUM_SLOTS(NUM_SLOTS)) u_legal (
        .prog     (prog_q),
        .conflict (conflict),
        .loop     (loop)
    );

    sgf_eval #(.NUM_INPUTS(NUM_INPUTS), .NUM_SLOTS(NUM_SLOTS)) u_eval (
        .clk     (clk),
        .rst     (rst),
        .clr     (cfg_clr),
        .en      (en),
        .in_bits (in_bits),
        .prog    (prog_q),
        .wires   (wires),
        .state_q (state_q)
    );

    assign prog_err = conflict | loop;
    assign out_bit  = prog_err ? 1'b0 : wires[tap_q];

endmodule

// File: rtl/sgf_fabric_chk.sv
module sgf_fabric_chk
    import sgf_pkg::*;
#(
    parameter int NUM_INPUTS = 4,
    parameter int NUM_SLOTS  = 8
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  en,
    input logic                  clr,
    input logic [NUM_INPUTS-1:0] in_bits,
    input logic [WIRE_W-1:0]     tap_q,
    input logic [NUM_SLOTS-1:0]  state_q,
    input logic                  out_bit,
    input logic                  prog_err
);

    logic [SGF_WIRES-1:0] in_ext;
    assign in_ext = SGF_WIRES'(in_bits);

    // R8 R9
    err_forces_zero_chk: assert property (@(posedge clk) disable iff (rst)
        prog_err |-> !out_bit);

    // R6
    load_clears_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (state_q == '0));

    // R7
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!en && !clr) |=> $stable(state_q));

    // R3
    input_tap_chk: assert property (@(posedge clk) disable iff (rst)
        (!prog_err && int'(tap_q) < NUM_INPUTS) |-> (out_bit == in_ext[tap_q]));

    // R1
    reset_clean_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!prog_err && state_q == '0 && tap_q == '0));

endmodule

bind sgf_fabric sgf_fabric_chk #(.NUM_INPUTS(NUM_INPUTS), .NUM_SLOTS(NUM_SLOTS)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .clr      (cfg_clr),
    .in_bits  (in_bits),
    .tap_q    (tap_q),
    .state_q  (state_q),
    .out_bit  (out_bit),
    .prog_err (prog_err)
);

// File: tb/sgf_fabric_test.sv
`timescale 1ns/1ps
module sgf_fabric_test;
    import sgf_pkg::*;

    localparam int NI = 4;
    localparam int NS = 8;
    localparam int AW = $clog2(NS + 1);

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               prog_we = 1'b0;
    logic [AW-1:0]      prog_addr = '0;
    logic [INSTR_W-1:0] prog_data = '0;
    logic               en = 1'b0;
    logic [NI-1:0]      in_bits = '0;
    logic               out_bit;
    logic               prog_err;

    int  total = 0;
    int  fails = 0;
    bit  finished = 1'b0;

    instr_t         m_prog [NS];
    logic [3:0]     m_tap;
    logic           m_st [NS];
    logic [15:0]    m_w;
    bit             m_err;
    logic           last_out;

    always #2.5 clk = ~clk;

    sgf_fabric #(.NUM_INPUTS(NI), .NUM_SLOTS(NS)) uut (
        .clk(clk), .rst(rst), .prog_we(prog_we), .prog_addr(prog_addr),
        .prog_data(prog_data), .en(en), .in_bits(in_bits),
        .out_bit(out_bit), .prog_err(prog_err)
    );

    task automatic check(input string tag, input logic got, input logic exp);
        total++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0b expected %0b", tag, got, exp);
        end
    endtask

    task automatic check_int(input string tag, input int got, input int exp);
        total++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    function automatic instr_t mk(input op_e op, input int a, input int b,
                                  input int s, input int d);
        instr_t r;
        r.vld = 1'b1;
        r.op  = op;
        r.a   = 4'(a);
        r.b   = 4'(b);
        r.s   = 4'(s);
        r.d   = 4'(d);
        return r;
    endfunction

    // Reference evaluation: worklist over instructions in readiness order.
    task automatic model_eval(input logic [NI-1:0] ib);
        bit [15:0] known;
        bit [15:0] seen;
        bit [NS-1:0] done;
        bit conflict;
        m_w = '0; known = '0; seen = '0; conflict = 0;
        for (int i = 0; i < NI; i++) begin
            m_w[i] = ib[i]; known[i] = 1; seen[i] = 1;
        end
        for (int s = 0; s < NS; s++) begin
            if (m_prog[s].vld) begin
                if (seen[m_prog[s].d]) conflict = 1;
                seen[m_prog[s].d] = 1;
            end
        end
        for (int s = 0; s < NS; s++) begin
            if (m_prog[s].vld && (m_prog[s].op == OP_DFF || m_prog[s].op == OP_TFF)) begin
                m_w[m_prog[s].d] = m_st[s];
                known[m_prog[s].d] = 1;
            end
        end
        for (int x = 0; x < 16; x++) if (!seen[x]) known[x] = 1;
        for (int s = 0; s < NS; s++)
            done[s] = !(m_prog[s].vld && m_prog[s].op != OP_DFF && m_prog[s].op != OP_TFF);
        for (int r = 0; r < NS; r++) begin
            for (int s = 0; s < NS; s++) begin
                if (!done[s]) begin
                    automatic instr_t q = m_prog[s];
                    automatic bit nb = (q.op == OP_AND || q.op == OP_OR ||
                                        q.op == OP_XOR || q.op == OP_MUX);
                    automatic bit ns = (q.op == OP_MUX);
                    if (known[q.a] && (!nb || known[q.b]) && (!ns || known[q.s])) begin
                        case (q.op)
                            OP_AND:  m_w[q.d] = m_w[q.a] & m_w[q.b];
                            OP_OR:   m_w[q.d] = m_w[q.a] | m_w[q.b];
                            OP_XOR:  m_w[q.d] = m_w[q.a] ^ m_w[q.b];
                            OP_NOT:  m_w[q.d] = ~m_w[q.a];
                            OP_PASS: m_w[q.d] = m_w[q.a];
                            default: m_w[q.d] = m_w[q.s] ? m_w[q.a] : m_w[q.b];
                        endcase
                        known[q.d] = 1;
                        done[s] = 1;
                    end
                end
            end
        end
        m_err = conflict || (done != '1);
    endtask

    task automatic clear_state();
        for (int s = 0; s < NS; s++) m_st[s] = 1'b0;
    endtask

    task automatic load(input int addr, input logic [INSTR_W-1:0] data);
        @(negedge clk);
        prog_we = 1'b1; prog_addr = AW'(addr); prog_data = data; en = 1'b1;
        @(posedge clk);
        if (addr < NS) m_prog[addr] = instr_t'(data);
        else if (addr == NS) m_tap = data[3:0];
        if (addr <= NS) clear_state();
        #1 prog_we = 1'b0;
    endtask

    task automatic clear_prog(input int tap);
        for (int s = 0; s < NS; s++) load(s, '0);
        load(NS, INSTR_W'(tap));
    endtask

    task automatic step(input string tag, input logic [NI-1:0] ib, input bit e);
        logic exp_out;
        @(negedge clk);
        in_bits = ib; en = e;
        #1;
        model_eval(ib);
        exp_out = m_err ? 1'b0 : m_w[m_tap];
        check(tag, prog_err, m_err);
        check(tag, out_bit, exp_out);
        last_out = out_bit;
        @(posedge clk);
        if (e) begin
            for (int s = 0; s < NS; s++) begin
                if (m_prog[s].vld && m_prog[s].op == OP_DFF) m_st[s] = m_w[m_prog[s].a];
                else if (m_prog[s].vld && m_prog[s].op == OP_TFF) m_st[s] = m_st[s] ^ m_w[m_prog[s].a];
                else m_st[s] = 1'b0;
            end
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++; fails++;
            $display("FAIL watchdog R1..: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] xs, ys;
        logic [NI-1:0] pat [6];
        logic outs_a [6];
        int ones;
        void'($urandom(32'h5eed));
        for (int s = 0; s < NS; s++) begin m_prog[s] = '0; m_st[s] = 0; end
        m_tap = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1: reset state
        @(negedge clk); in_bits = 4'b0101; #1;
        check("R1 err after reset", prog_err, 1'b0);
        check("R1 out follows in0", out_bit, 1'b1);
        step("R1", 4'b1010, 1);

        // R2 R3: AND via the worked stream pair
        load(0, mk(OP_AND, 0, 1, 0, 4));
        load(NS, INSTR_W'(4));
        xs = 8'b11101110; ys = 8'b01110010; ones = 0;
        for (int k = 7; k >= 0; k--) begin
            step("R3 and", {2'b00, ys[k], xs[k]}, 1);
            ones += int'(last_out);
        end
        check_int("R3 and ones count", ones, 3);
        check_int("R2 slot load visible", int'(prog_err), 0);

        // R3: other gates
        clear_prog(4);
        load(0, mk(OP_OR, 0, 1, 0, 4));
        load(1, mk(OP_XOR, 0, 1, 0, 5));
        load(2, mk(OP_NOT, 2, 0, 0, 6));
        load(3, mk(OP_PASS, 3, 0, 0, 7));
        load(4, mk(OP_MUX, 0, 1, 2, 8));
        for (int t = 4; t <= 8; t++) begin
            load(NS, INSTR_W'(t));
            for (int k = 0; k < 6; k++) step("R3 gates", 4'($urandom), 1);
        end
        load(NS, INSTR_W'(8));
        step("R3 mux", 4'b0101, 1);
        check("R3 mux sel1 picks A", last_out, 1'b1);
        step("R3 mux", 4'b0001, 1);
        check("R3 mux sel0 picks B", last_out, 1'b0);

        // R4 R7: delay cell and enable hold
        clear_prog(4);
        load(0, mk(OP_DFF, 0, 0, 0, 4));
        step("R4", 4'b0001, 1);
        check("R4 first out from cleared cell", last_out, 1'b0);
        step("R4", 4'b0000, 1);
        check("R4 delayed one", last_out, 1'b1);
        step("R4", 4'b0001, 1);
        check("R4 delayed zero", last_out, 1'b0);
        step("R7", 4'b0000, 0);
        check("R7 hold", last_out, 1'b1);
        step("R7", 4'b0000, 0);
        check("R7 hold again", last_out, 1'b1);
        step("R7", 4'b0000, 1);
        step("R7", 4'b0000, 1);
        check("R7 resumes", last_out, 1'b0);

        // R5 R6: toggle cell and clearing on load
        load(0, mk(OP_TFF, 0, 0, 0, 4));
        step("R5", 4'b0001, 1);
        step("R5", 4'b0001, 1);
        check("R5 toggled", last_out, 1'b1);
        step("R5", 4'b0000, 1);
        check("R5 back", last_out, 1'b0);
        step("R5", 4'b0001, 1);
        step("R5", 4'b0000, 1);
        check("R5 toggled again", last_out, 1'b1);
        load(NS, INSTR_W'(4));
        step("R6", 4'b0000, 1);
        check("R6 cleared by tap write", last_out, 1'b0);

        // R8: conflicts
        clear_prog(5);
        load(0, mk(OP_PASS, 0, 0, 0, 5));
        load(1, mk(OP_NOT, 1, 0, 0, 5));
        step("R8 double drive", 4'b1111, 1);
        check("R8 err set", prog_err, 1'b1);
        check("R8 out zero", last_out, 1'b0);
        clear_prog(2);
        load(0, mk(OP_PASS, 1, 0, 0, 2));
        step("R8 input target", 4'b0100, 1);
        check("R8 input target err", prog_err, 1'b1);
        check("R8 input target out", last_out, 1'b0);

        // R9: loops
        clear_prog(4);
        load(0, mk(OP_NOT, 5, 0, 0, 4));
        load(1, mk(OP_PASS, 4, 0, 0, 5));
        step("R9 comb loop", 4'b1111, 1);
        check("R9 loop err", prog_err, 1'b1);
        load(0, mk(OP_DFF, 5, 0, 0, 4));
        load(1, mk(OP_NOT, 4, 0, 0, 5));
        step("R9 registered loop", 4'b0000, 1);
        check("R9 registered legal", prog_err, 1'b0);
        step("R9 registered loop", 4'b0000, 1);
        check("R9 registered toggles", last_out, 1'b1);

        // R10: slot order
        for (int k = 0; k < 6; k++) pat[k] = 4'($urandom);
        clear_prog(6);
        load(0, mk(OP_AND, 0, 1, 0, 4));
        load(1, mk(OP_XOR, 4, 2, 0, 5));
        load(2, mk(OP_MUX, 5, 3, 0, 6));
        for (int k = 0; k < 6; k++) begin
            step("R10 forward", pat[k], 1);
            outs_a[k] = last_out;
        end
        clear_prog(6);
        load(7, mk(OP_AND, 0, 1, 0, 4));
        load(6, mk(OP_XOR, 4, 2, 0, 5));
        load(5, mk(OP_MUX, 5, 3, 0, 6));
        for (int k = 0; k < 6; k++) begin
            step("R10 reversed", pat[k], 1);
            check("R10 same stream", last_out, outs_a[k]);
        end

        // R12: full-depth chain stored backwards
        clear_prog(11);
        for (int k = 0; k < NS; k++) begin
            if (k == 0) load(NS - 1, mk(OP_PASS, 0, 0, 0, 4));
            else load(NS - 1 - k, mk(OP_NOT, 3 + k, 0, 0, 4 + k));
        end
        step("R12 chain", 4'b0001, 1);
        check("R12 chain in1", last_out, 1'b0);
        step("R12 chain", 4'b0000, 1);
        check("R12 chain in0", last_out, 1'b1);

        // R11: undriven wire
        clear_prog(12);
        step("R11 undriven", 4'b1111, 1);
        check("R11 reads zero", last_out, 1'b0);

        // Random programs against the reference (R3 R4 R5 R8 R9)
        for (int p = 0; p < 40; p++) begin
            for (int s = 0; s < NS; s++) begin
                instr_t r;
                r = mk(op_e'($urandom % 8), $urandom % 16, $urandom % 16,
                       $urandom % 16, 4 + ($urandom % 12));
                r.vld = ($urandom % 4) != 0;
                load(s, r);
            end
            load(NS, INSTR_W'($urandom % 16));
            for (int c = 0; c < 20; c++)
                step("R3 R4 R5 R8 R9 random", 4'($urandom), ($urandom % 4) != 0);
        end

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule